// File: doc/BRIEF.md
# Thread-Partitioned Write-Back Data Cache

This block is the data cache of a fine-grained multithreaded pipeline. One shared set of tag and data arrays is split into private partitions, one per hardware thread. Each partition is a small direct-mapped cache of 32-byte lines. The line index is the thread number joined with the low line-address bits, so two threads can never evict each other. The cache is write-back and write-allocate, and every tag holds a parity bit.

The pipeline presents a thread number, a word address, a read/write flag, four byte enables and a 32-bit word. One cycle later the cache answers with either data (a hit) or a replay indication. On a replay the pipeline issues the same access again on that thread's next turn. A miss blocks only its own thread, and the other threads go on hitting while the refill is outstanding. A separate memory port moves whole 256-bit lines to and from a memory controller. It serves the outstanding misses one at a time, in the order they arrived. A dirty victim is written back before the line is fetched.

Top module: `thread_part_dcache`

## Requirements
- R1: After reset no response and no memory request is active, and every line of every thread is invalid, so the first access to any address misses.
- R2: An access in cycle n gives `rspValid` in cycle n+1, with exactly one of `rspHit` or `rspReplay` set. A load hit returns word `cpuWordAddr[2:0]` of the line, where word w sits in line bits [32w+31:32w]. No response appears without an access.
- R3: An access that misses in the thread's own partition answers with a replay and marks the thread blocked. Stores allocate too: a store that misses is repeated and hits once the line is filled.
- R4: While a thread is blocked, all of its accesses answer with a replay, even for lines it holds. This includes an access in the same cycle the refill is written. The first access after that cycle is looked up normally.
- R5: A blocked thread never delays another thread. Other threads' hits return data with the normal one-cycle latency while any refill is outstanding.
- R6: A store hit writes only the bytes whose `cpuByteEn[b]` is set (byte b = bits [8b+7:8b] of the word) and returns the merged word. It marks the line dirty, and later loads return the merged value.
- R7: When the victim line is valid and dirty, a write request carrying the victim's line address and all 256 bits comes before the refill read, in the very next request. A clean or invalid victim causes no write.
- R8: Misses are served one at a time in arrival order, and each makes exactly one read at the missing line address. A request holds its address and kind until `memReqReady` accepts it.
- R9: Each thread owns its own partition: 8 lines per thread when there are more than 32 threads, and 32 lines otherwise. The same address used by two threads occupies two lines. Two addresses in one thread that share the low line-address bits (256 bytes apart in the default build) evict each other.
- R10: Each lookup checks the stored tag parity. A mismatch answers with a replay and `rspParErr`, and invalidates the line without write-back. Lines filled through the memory port never report a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Access present this cycle |
| cpuThread | input | TID_W | Thread issuing the access |
| cpuWordAddr | input | ADDR_W-2 | Physical word address |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuByteEn | input | 4 | Byte enables for stores |
| cpuWdata | input | 32 | Store data |
| rspValid | output | 1 | Response for the previous cycle's access |
| rspHit | output | 1 | Access hit, data valid |
| rspReplay | output | 1 | Access must be reissued |
| rspParErr | output | 1 | Tag parity mismatch seen |
| rspThread | output | TID_W | Thread of the response |
| rspData | output | 32 | Load word or merged store word |
| memReqValid | output | 1 | Memory request pending |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = write-back, 0 = line read |
| memReqAddr | output | ADDR_W-5 | Line address |
| memReqWdata | output | 256 | Victim line for write-back |
| memRspValid | input | 1 | Refill data present |
| memRspData | input | 256 | Refill line |

## Verification
The bench first tries single loads and partial-byte stores on lines that are already present. This separates correct word selection from correct byte merging. It then makes a same-thread conflict on a dirty line while a second thread keeps hitting. This separates the write-back ordering and its contents from any slip in the other thread's latency. The replayed reload of the evicted address shows that the written-back bytes reached memory. Back-to-back misses from several threads check arrival-order service. A long stretch of mixed loads and stores, on eight threads over a handful of conflicting lines with a stalling memory port, shows the partitions stay independent under pressure.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int OFF_W  = 5;
  localparam int LINE_W = 256;
  localparam int HALF_W = 128;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_WB    = 2'd1,
    MS_FETCH = 2'd2,
    MS_WAIT  = 2'd3
  } memSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fillWe;   // write refill line, tag, valid
    logic wbRead;   // drive victim line onto write-back data
  } dpStrobe_t;
endpackage

// File: rtl/tpd_order_fifo.sv
module tpd_order_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wrPtr] <= pushData;
  end

  assign head  = slot[rdPtr];
  assign empty = (count == '0);
endmodule

// File: rtl/tpd_datapath.sv
module tpd_datapath
  import tpd_pkg::*;
#(
  parameter int NUM_THREADS = 64,
  parameter int ADDR_W      = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuValid,
  input  logic [$clog2(NUM_THREADS)-1:0] cpuThread,
  input  logic [ADDR_W-3:0]        cpuWordAddr,
  input  logic                     cpuWrite,
  input  logic [3:0]               cpuByteEn,
  input  logic [31:0]              cpuWdata,
  input  logic [NUM_THREADS-1:0]   threadBusy,
  input  dpStrobe_t                strobe,
  input  logic [$clog2(NUM_THREADS)+$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0] fillLine,
  input  logic [ADDR_W-OFF_W-$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0]       fillTag,
  input  logic [LINE_W-1:0]        fillData,
  input  logic [$clog2(NUM_THREADS)+$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0] svcLine,
  output logic                     missNew,
  output logic                     vicNeedWb,
  output logic [ADDR_W-OFF_W-$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0]       vicTag,
  output logic [LINE_W-1:0]        vicData,
  output logic                     rspValid,
  output logic                     rspHit,
  output logic                     rspReplay,
  output logic                     rspParErr,
  output logic [$clog2(NUM_THREADS)-1:0] rspThread,
  output logic [31:0]              rspData
);
  localparam int TID_W   = $clog2(NUM_THREADS);
  localparam int LINES   = (NUM_THREADS <= 32) ? 32 : 8;
  localparam int IDX_W   = $clog2(LINES);
  localparam int LA_W    = ADDR_W - OFF_W;
  localparam int TAG_W   = LA_W - IDX_W;
  localparam int LINE_AW = TID_W + IDX_W;
  localparam int NLINES  = NUM_THREADS * LINES;

  logic [TAG_W-1:0]  tagArr  [NLINES];
  logic [HALF_W-1:0] dataArr [NLINES*2];
  logic [NLINES-1:0] tagPar;
  logic [NLINES-1:0] lineValid;
  logic [NLINES-1:0] lineDirty;

  // lookup decode
  logic [LA_W-1:0]    reqLa;
  logic [TAG_W-1:0]   reqTag;
  logic [LINE_AW-1:0] lkLine;
  logic [LINE_AW:0]   lkHalf;
  logic [1:0]         wordSel;
  logic [HALF_W-1:0]  halfRd, halfWr;
  logic [31:0]        wordRd, mergedWord;
  logic               blocked, parOk, tagEq, parErr, hit;

  assign reqLa   = cpuWordAddr[ADDR_W-3:3];
  assign reqTag  = reqLa[LA_W-1:IDX_W];
  assign lkLine  = {cpuThread, reqLa[IDX_W-1:0]};
  assign lkHalf  = {lkLine, cpuWordAddr[2]};
  assign wordSel = cpuWordAddr[1:0];

  assign halfRd  = dataArr[lkHalf];
  assign wordRd  = halfRd[{wordSel, 5'b0} +: 32];

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      mergedWord[8*b +: 8] = cpuByteEn[b] ? cpuWdata[8*b +: 8] : wordRd[8*b +: 8];
    end
    halfWr = halfRd;
    halfWr[{wordSel, 5'b0} +: 32] = mergedWord;
  end

  assign blocked = threadBusy[cpuThread];
  assign parOk   = ((^tagArr[lkLine]) == tagPar[lkLine]);
  assign tagEq   = (tagArr[lkLine] == reqTag);
  assign parErr  = cpuValid && !blocked && lineValid[lkLine] && !parOk;
  assign hit     = cpuValid && !blocked && lineValid[lkLine] && parOk && tagEq;
  assign missNew = cpuValid && !blocked && !hit;

  // CPU store port and refill port on the data array
  always_ff @(posedge clk) begin
    if (hit && cpuWrite) dataArr[lkHalf] <= halfWr;
    if (strobe.fillWe) begin
      dataArr[{fillLine, 1'b0}] <= fillData[HALF_W-1:0];
      dataArr[{fillLine, 1'b1}] <= fillData[LINE_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWe) begin
      tagArr[fillLine] <= fillTag;
      tagPar[fillLine] <= ^fillTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
      lineDirty <= '0;
    end else begin
      if (parErr)          lineValid[lkLine] <= 1'b0;
      if (hit && cpuWrite) lineDirty[lkLine] <= 1'b1;
      if (strobe.fillWe) begin
        lineValid[fillLine] <= 1'b1;
        lineDirty[fillLine] <= 1'b0;
      end
    end
  end

  // victim read port for the memory side
  assign vicNeedWb = lineValid[svcLine] && lineDirty[svcLine];
  assign vicTag    = tagArr[svcLine];
  assign vicData   = strobe.wbRead ? {dataArr[{svcLine, 1'b1}], dataArr[{svcLine, 1'b0}]}
                                   : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspReplay <= 1'b0;
      rspParErr <= 1'b0;
      rspThread <= '0;
      rspData   <= '0;
    end else begin
      rspValid  <= cpuValid;
      rspHit    <= hit;
      rspReplay <= cpuValid && !hit;
      rspParErr <= parErr;
      rspThread <= cpuThread;
      rspData   <= hit ? (cpuWrite ? mergedWord : wordRd) : 32'h0;
    end
  end
endmodule

// File: rtl/tpd_control.sv
module tpd_control
  import tpd_pkg::*;
#(
  parameter int NUM_THREADS = 64,
  parameter int ADDR_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   missNew,
  input  logic [$clog2(NUM_THREADS)-1:0] cpuThread,
  input  logic [ADDR_W-OFF_W-1:0] missLineAddr,
  input  logic                   vicNeedWb,
  input  logic [ADDR_W-OFF_W-$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0] vicTag,
  input  logic [LINE_W-1:0]      vicData,
  input  logic                   memReqReady,
  input  logic                   memRspValid,
  output logic [NUM_THREADS-1:0] threadBusy,
  output dpStrobe_t              strobe,
  output logic [$clog2(NUM_THREADS)+$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0] fillLine,
  output logic [ADDR_W-OFF_W-$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0]       fillTag,
  output logic [$clog2(NUM_THREADS)+$clog2((NUM_THREADS <= 32) ? 32 : 8)-1:0] svcLine,
  output logic                   memReqValid,
  output logic                   memReqWrite,
  output logic [ADDR_W-OFF_W-1:0] memReqAddr,
  output logic [LINE_W-1:0]      memReqWdata
);
  localparam int TID_W = $clog2(NUM_THREADS);
  localparam int LINES = (NUM_THREADS <= 32) ? 32 : 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int LA_W  = ADDR_W - OFF_W;

  memSt_e           state;
  logic [TID_W-1:0] curThr, headThr, svcThr;
  logic [LA_W-1:0]  missLa [NUM_THREADS];
  logic             qEmpty, qPop;

  tpd_order_fifo #(.DEPTH(NUM_THREADS), .W(TID_W)) order_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (missNew),
    .pushData (cpuThread),
    .pop      (qPop),
    .head     (headThr),
    .empty    (qEmpty)
  );

  assign qPop   = (state == MS_IDLE) && !qEmpty;
  assign svcThr = (state == MS_IDLE) ? headThr : curThr;
  assign svcLine  = {svcThr, missLa[svcThr][IDX_W-1:0]};
  assign fillLine = {curThr, missLa[curThr][IDX_W-1:0]};
  assign fillTag  = missLa[curThr][LA_W-1:IDX_W];

  assign strobe.fillWe = (state == MS_WAIT) && memRspValid;
  assign strobe.wbRead = (state == MS_WB);

  assign memReqValid = (state == MS_WB) || (state == MS_FETCH);
  assign memReqWrite = (state == MS_WB);
  assign memReqAddr  = (state == MS_WB) ? {vicTag, missLa[curThr][IDX_W-1:0]}
                                        : missLa[curThr];
  assign memReqWdata = vicData;

  always_ff @(posedge clk) begin
    if (missNew) missLa[cpuThread] <= missLineAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threadBusy <= '0;
      state      <= MS_IDLE;
      curThr     <= '0;
    end else begin
      if (missNew)       threadBusy[cpuThread] <= 1'b1;
      if (strobe.fillWe) threadBusy[curThr]    <= 1'b0;
      unique case (state)
        MS_IDLE: if (!qEmpty) begin
          curThr <= headThr;
          state  <= vicNeedWb ? MS_WB : MS_FETCH;
        end
        MS_WB:    if (memReqReady) state <= MS_FETCH;
        MS_FETCH: if (memReqReady) state <= MS_WAIT;
        MS_WAIT:  if (memRspValid) state <= MS_IDLE;
        default:  state <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thread_part_dcache.sv
module thread_part_dcache
  import tpd_pkg::*;
#(
  parameter int NUM_THREADS = 64,
  parameter int ADDR_W      = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cpuValid,
  input  logic [$clog2(NUM_THREADS)-1:0] cpuThread,
  input  logic [ADDR_W-3:0]              cpuWordAddr,
  input  logic                           cpuWrite,
  input  logic [3:0]                     cpuByteEn,
  input  logic [31:0]                    cpuWdata,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic                           rspReplay,
  output logic                           rspParErr,
  output logic [$clog2(NUM_THREADS)-1:0] rspThread,
  output logic [31:0]                    rspData,
  output logic                           memReqValid,
  input  logic                           memReqReady,
  output logic                           memReqWrite,
  output logic [ADDR_W-6:0]              memReqAddr,
  output logic [255:0]                   memReqWdata,
  input  logic                           memRspValid,
  input  logic [255:0]                   memRspData
);
  localparam int TID_W   = $clog2(NUM_THREADS);
  localparam int LINES   = (NUM_THREADS <= 32) ? 32 : 8;
  localparam int IDX_W   = $clog2(LINES);
  localparam int LA_W    = ADDR_W - OFF_W;
  localparam int TAG_W   = LA_W - IDX_W;
  localparam int LINE_AW = TID_W + IDX_W;

  logic [NUM_THREADS-1:0] threadBusy;
  dpStrobe_t              strobe;
  logic [LINE_AW-1:0]     fillLine, svcLine;
  logic [TAG_W-1:0]       fillTag, vicTag;
  logic [LINE_W-1:0]      vicData;
  logic                   missNew, vicNeedWb;

  tpd_datapath #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuValid    (cpuValid),
    .cpuThread   (cpuThread),
    .cpuWordAddr (cpuWordAddr),
    .cpuWrite    (cpuWrite),
    .cpuByteEn   (cpuByteEn),
    .cpuWdata    (cpuWdata),
    .threadBusy  (threadBusy),
    .strobe      (strobe),
    .fillLine    (fillLine),
    .fillTag     (fillTag),
    .fillData    (memRspData),
    .svcLine     (svcLine),
    .missNew     (missNew),
    .vicNeedWb   (vicNeedWb),
    .vicTag      (vicTag),
    .vicData     (vicData),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .rspReplay   (rspReplay),
    .rspParErr   (rspParErr),
    .rspThread   (rspThread),
    .rspData     (rspData)
  );

  tpd_control #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .missNew      (missNew),
    .cpuThread    (cpuThread),
    .missLineAddr (cpuWordAddr[ADDR_W-3:3]),
    .vicNeedWb    (vicNeedWb),
    .vicTag       (vicTag),
    .vicData      (vicData),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .threadBusy   (threadBusy),
    .strobe       (strobe),
    .fillLine     (fillLine),
    .fillTag      (fillTag),
    .svcLine      (svcLine),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .memReqAddr   (memReqAddr),
    .memReqWdata  (memReqWdata)
  );
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspReplay,
  input logic              rspParErr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-6:0] memReqAddr
);
  // R2
  rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> rspValid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuValid |=> !rspValid);

  // R2
  hit_xor_replay_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspHit != rspReplay));

  // R10
  parerr_is_replay_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspParErr |-> (rspValid && rspReplay));

  // R7
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memReqReady) |=> (memReqValid && !memReqWrite));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));
endmodule

bind thread_part_dcache tpd_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cpuValid    (cpuValid),
  .rspValid    (rspValid),
  .rspHit      (rspHit),
  .rspReplay   (rspReplay),
  .rspParErr   (rspParErr),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr)
);

// File: tb/thread_part_dcache_tb.sv
module thread_part_dcache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT       = 64;
  localparam int AW       = 32;
  localparam int LINES    = 8;
  localparam int LA_W     = AW - 5;
  localparam int FILL_LAT = 4;

  logic clk = 1'b0;
  logic rstN;
  logic cpuValid, cpuWrite;
  logic [5:0] cpuThread;
  logic [AW-3:0] cpuWordAddr;
  logic [3:0] cpuByteEn;
  logic [31:0] cpuWdata;
  logic rspValid, rspHit, rspReplay, rspParErr;
  logic [5:0] rspThread;
  logic [31:0] rspData;
  logic memReqValid, memReqReady, memReqWrite, memRspValid;
  logic [LA_W-1:0] memReqAddr;
  logic [255:0] memReqWdata, memRspData;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_part_dcache #(.NUM_THREADS(NT), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuThread(cpuThread),
    .cpuWordAddr(cpuWordAddr), .cpuWrite(cpuWrite), .cpuByteEn(cpuByteEn),
    .cpuWdata(cpuWdata), .rspValid(rspValid), .rspHit(rspHit),
    .rspReplay(rspReplay), .rspParErr(rspParErr), .rspThread(rspThread),
    .rspData(rspData), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // behavioural reference state
  logic [255:0]    memLine [logic [LA_W-1:0]];
  bit              cV     [NT*LINES];
  bit              cDirty [NT*LINES];
  logic [LA_W-1:0] cLa    [NT*LINES];
  logic [255:0]    cD     [NT*LINES];
  bit              pend   [NT];
  logic [LA_W-1:0] pLa    [NT];
  int              missQ  [$];
  bit wbDone, readIssued;
  int fillCnt;
  int nCmp, nBad, cyc;
  bit done;

  bit          prevOp, prevHit;
  logic [31:0] prevData;
  logic [5:0]  prevThr;
  string       prevTag;

  function automatic logic [255:0] getMem(logic [LA_W-1:0] la);
    logic [255:0] v;
    if (memLine.exists(la)) return memLine[la];
    for (int w = 0; w < 8; w++) v[32*w +: 32] = ({5'b0, la} * 32'd8 + w) ^ 32'h5A5A_0000;
    return v;
  endfunction

  function automatic int keyOf(int tid, logic [LA_W-1:0] la);
    return tid * LINES + int'(la % LINES);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit doOp, int tid, logic [AW-1:0] addr, bit wr,
                      logic [3:0] be, logic [31:0] wd, string ovr);
    bit fillNow;
    fillNow = 0;
    // response for the access driven one cycle earlier
    if (prevOp) begin
      check(rspValid === 1'b1 && rspHit === prevHit && rspReplay === !prevHit &&
            rspThread === prevThr && (!prevHit || rspData === prevData),
            prevTag, "response {valid,hit,replay,data}",
            {rspValid, rspHit, rspReplay, rspData}, {1'b1, prevHit, !prevHit, prevData});
      check(rspParErr === 1'b0, "R10", "parity error flag", rspParErr, 0);
    end else begin
      check(rspValid === 1'b0, "R2", "response without access", rspValid, 0);
    end
    // refill pulse
    memRspValid = 1'b0;
    if (fillCnt > 0) begin
      fillCnt--;
      if (fillCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = getMem(pLa[missQ[0]]);
        fillNow     = 1;
      end
    end
    // request side, handshake at the coming edge
    memReqReady = (cyc % 3) != 2;
    if (memReqValid === 1'b1 && memReqReady) begin
      if (missQ.size() == 0) begin
        check(0, "R8", "request with no outstanding miss", memReqAddr, 0);
      end else begin
        int f, k;
        bit vd;
        f = missQ[0];
        k = keyOf(f, pLa[f]);
        vd = cV[k] && cDirty[k];
        if (memReqWrite === 1'b1) begin
          check(vd && !wbDone, "R7", "write-back only for a dirty victim", wbDone, 0);
          check(memReqAddr === cLa[k], "R7", "write-back line address", memReqAddr, cLa[k]);
          check(memReqWdata === cD[k], "R7", "write-back contents", memReqWdata, cD[k]);
          memLine[cLa[k]] = cD[k];
          wbDone = 1;
        end else begin
          check(memReqAddr === pLa[f] && !readIssued, "R8", "refill read address (arrival order)",
                memReqAddr, pLa[f]);
          check(wbDone == vd, "R7", "write-back done before refill read", wbDone, vd);
          readIssued = 1;
          fillCnt = FILL_LAT;
        end
      end
    end
    // CPU access and its expected outcome
    cpuValid    = doOp;
    cpuThread   = tid[5:0];
    cpuWordAddr = addr[AW-1:2];
    cpuWrite    = wr;
    cpuByteEn   = be;
    cpuWdata    = wd;
    prevOp = doOp;
    if (doOp) begin
      logic [LA_W-1:0] la;
      int k, w;
      bit others;
      la = addr[AW-1:5];
      k = keyOf(tid, la);
      w = int'(addr[4:2]);
      others = 0;
      for (int t = 0; t < NT; t++) if (t != tid && pend[t]) others = 1;
      prevThr = tid[5:0];
      if (pend[tid]) begin
        prevHit = 0; prevTag = "R4";
      end else if (cV[k] && cLa[k] == la) begin
        logic [31:0] word;
        word = cD[k][32*w +: 32];
        if (wr) begin
          for (int b = 0; b < 4; b++) if (be[b]) word[8*b +: 8] = wd[8*b +: 8];
          cD[k][32*w +: 32] = word;
          cDirty[k] = 1;
        end
        prevHit = 1; prevData = word;
        prevTag = wr ? "R6" : (others ? "R5" : "R2");
      end else begin
        prevHit = 0; prevTag = "R3";
        pend[tid] = 1; pLa[tid] = la;
        missQ.push_back(tid);
      end
      if (ovr != "") prevTag = ovr;
    end
    // refill lands at the coming edge
    if (fillNow) begin
      int f, k;
      f = missQ.pop_front();
      k = keyOf(f, pLa[f]);
      cV[k] = 1; cLa[k] = pLa[f]; cD[k] = memRspData; cDirty[k] = 0;
      pend[f] = 0; wbDone = 0; readIssued = 0;
    end
    cyc++;
  endtask

  task automatic op(int tid, logic [AW-1:0] addr, bit wr, logic [3:0] be,
                    logic [31:0] wd, string tag);
    @(negedge clk);
    step(1, tid, addr, wr, be, wd, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step(0, 0, 0, 0, 0, 0, "");
    end
  endtask

  task automatic quiet();
    while (missQ.size() > 0 || fillCnt > 0) idle(1);
    idle(2);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    nCmp = 0; nBad = 0; cyc = 0; fillCnt = 0; done = 0;
    wbDone = 0; readIssued = 0; prevOp = 0;
    for (int i = 0; i < NT*LINES; i++) begin cV[i] = 0; cDirty[i] = 0; end
    for (int t = 0; t < NT; t++) pend[t] = 0;
    rstN = 1'b0; cpuValid = 0; cpuThread = 0; cpuWordAddr = 0; cpuWrite = 0;
    cpuByteEn = 0; cpuWdata = 0; memReqReady = 0; memRspValid = 0; memRspData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(rspValid === 1'b0, "R1", "rspValid after reset", rspValid, 0);
    check(memReqValid === 1'b0, "R1", "memReqValid after reset", memReqValid, 0);

    // R1/R9: cold misses, same address from two threads
    op(1, 32'h1000, 0, 4'h0, 0, "R1");
    op(2, 32'h1000, 0, 4'h0, 0, "R9");
    quiet();
    op(1, 32'h1004, 0, 4'h0, 0, "R2");
    op(2, 32'h1000, 0, 4'h0, 0, "R9");
    // R6: partial store then reload
    op(1, 32'h1008, 1, 4'b0101, 32'hDEAD_BEEF, "R6");
    op(1, 32'h1008, 0, 4'h0, 0, "R6");
    // R9/R7: conflict 256 bytes apart with a dirty victim; R5/R4 meanwhile
    op(1, 32'h1100, 0, 4'h0, 0, "R9");
    for (int i = 0; i < 8; i++) begin
      op(2, 32'h1000 + 4*(i % 8), 0, 4'h0, 0, "R5");
      op(1, 32'h1004, 0, 4'h0, 0, "R4");
    end
    quiet();
    // reload of the evicted line shows the written-back bytes (R7)
    op(1, 32'h1008, 0, 4'h0, 0, "R3");
    quiet();
    op(1, 32'h1008, 0, 4'h0, 0, "R7");
    // R3: store miss allocates, replayed store hits
    op(3, 32'h2010, 1, 4'b1111, 32'h1234_5678, "R3");
    quiet();
    op(3, 32'h2010, 1, 4'b1000, 32'hAB00_0000, "R3");
    op(3, 32'h2010, 0, 4'h0, 0, "R6");
    // R8: back-to-back misses of several threads
    op(4, 32'h3000, 0, 4'h0, 0, "R8");
    op(5, 32'h3020, 0, 4'h0, 0, "R8");
    op(6, 32'h3040, 0, 4'h0, 0, "R8");
    op(3, 32'h2010, 0, 4'h0, 0, "R5");
    quiet();
    op(6, 32'h3040, 0, 4'h0, 0, "R8");

    // mixed traffic on eight threads over conflicting lines
    for (int i = 0; i < 1500; i++) begin
      int t, sel, ix, wi;
      t   = $urandom_range(7);
      sel = $urandom_range(3);
      ix  = $urandom_range(7);
      wi  = $urandom_range(7);
      if ($urandom_range(4) == 0) idle(1);
      op(t, 32'h0004_0000 + (sel << 8) + (ix << 5) + (wi << 2),
         $urandom_range(9) < 3, 4'($urandom_range(15)), $urandom, "");
    end
    quiet();
    done = 1;
    finishRun();
  end
endmodule